// File: doc/BRIEF.md
# 8b/10b Transmit Character Encoder with Disparity Override

This block turns one byte per clock, with a flag that marks it as a control character, into a 10-bit DC-balanced transmission character. It keeps its own running disparity from one character to the next, so the transmitted line stays balanced without help from the user logic. Each character is built from a 6-bit subblock, which comes from the low five data bits, and a 4-bit subblock, which comes from the high three bits. The 6-bit subblock goes out first.

For one character at a time, the user can replace the tracked running disparity with a value of their own. When the force flag is raised with a valid byte, that character is encoded starting from the supplied disparity. The tracked disparity then continues from the result of that character. A byte flagged as control that is not one of the twelve legal control characters raises an error flag. It is still sent as the ordinary data character for the same byte, with correct disparity. Results come out registered, one cycle after the input.

Top module: `tx_char_encoder`

## Requirements
- R1: While reset is held and after it is released, out_valid and out_kerr are 0 and out_rd is 0. out_rd = 0 means negative running disparity and out_rd = 1 means positive.
- R2: out_valid in a cycle equals in_valid in the previous cycle. The code, disparity and error of a character appear one clock after it is presented.
- R3: A data byte HGFEDCBA (bit 7 = H) with in_ctrl = 0 is encoded with the standard 5b/6b and 3b/4b tables. out_code[9:4] holds abcdei, with a at bit 9, and out_code[3:0] holds fghj, with f at bit 3. Bit 9 is sent first. Examples: D.0.0 from negative disparity gives 10'b1001110100, and D.11.7 from positive disparity gives 10'b1101001000.
- R4: After each valid character, out_rd is the starting disparity inverted if the character has 4 or 6 ones, and unchanged if it has 5 ones.
- R5: Every character has 4, 5 or 6 ones. A character with 6 ones is produced only from a negative start, and one with 4 ones only from a positive start.
- R6: For D.x.7 the alternate fghj form (0111 or 1000) is used when x is 17, 18 or 20 and the disparity after the 6-bit subblock is negative. It is also used when x is 11, 13 or 14 and that disparity is positive. Otherwise the primary form (1110 or 0001) is used. Example: D.17.7 from negative disparity gives 10'b1000110111.
- R7: With in_ctrl = 1, the twelve control characters K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7 are encoded with the standard control table and out_kerr = 0. Example: K28.5 from negative disparity gives 10'b0011111010, and from positive disparity gives 10'b1100000101.
- R8: With in_ctrl = 1 and any other byte, out_kerr = 1 for that character, and out_code is the data character for the same byte with correct disparity.
- R9: With in_valid = 1 and in_force = 1, the character is encoded from the disparity on in_dispval (1 = positive). out_rd then follows R4 from that forced start, and later characters continue from it.
- R10: With in_force = 0, in_dispval has no effect on out_code or out_rd.
- R11: In a cycle with in_valid = 0, the next cycle shows out_valid = 0 and out_kerr = 0, and out_rd is unchanged whatever in_force and in_dispval are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte present this cycle |
| in_data | input | 8 | Byte to encode, bit 7 = H, bit 0 = A |
| in_ctrl | input | 1 | Byte is a control character |
| in_force | input | 1 | Encode this character from in_dispval |
| in_dispval | input | 1 | Forced starting disparity, 1 = positive |
| out_valid | output | 1 | out_code holds a new character |
| out_code | output | 10 | Encoded character, abcdei in [9:4] and fghj in [3:0] |
| out_rd | output | 1 | Running disparity after the last character, 1 = positive |
| out_kerr | output | 1 | Last character was an illegal control byte |

## Verification
Two things can happen on the same character: a disparity override, and an illegal control byte that falls back to data encoding. The bench sends illegal control bytes with in_force raised and in_dispval set to both values. The fallback character must then be balanced from the forced start, not from the tracked one, and must still raise out_kerr. A second overlap is the D.x.7 alternate choice under a forced start. The bench sweeps all 256 bytes from each forced disparity and compares every character and the resulting disparity with an independent two-column table model.

// File: rtl/txenc_pkg.sv
package txenc_pkg;

  localparam int DATA_W = 8;
  localparam int LOW_W  = 5;
  localparam int HIGH_W = DATA_W - LOW_W;
  localparam int SIX_W  = 6;
  localparam int FOUR_W = 4;
  localparam int CODE_W = SIX_W + FOUR_W;

  // 6-bit subblock (abcdei) for the negative-disparity column
  function automatic logic [SIX_W-1:0] six_neg(input logic [LOW_W-1:0] x,
                                               input logic k28);
    logic [SIX_W-1:0] c;
    if (k28) begin
      c = 6'b001111;
    end else begin
      unique case (x)
        5'd0:  c = 6'b100111;
        5'd1:  c = 6'b011101;
        5'd2:  c = 6'b101101;
        5'd3:  c = 6'b110001;
        5'd4:  c = 6'b110101;
        5'd5:  c = 6'b101001;
        5'd6:  c = 6'b011001;
        5'd7:  c = 6'b111000;
        5'd8:  c = 6'b111001;
        5'd9:  c = 6'b100101;
        5'd10: c = 6'b010101;
        5'd11: c = 6'b110100;
        5'd12: c = 6'b001101;
        5'd13: c = 6'b101100;
        5'd14: c = 6'b011100;
        5'd15: c = 6'b010111;
        5'd16: c = 6'b011011;
        5'd17: c = 6'b100011;
        5'd18: c = 6'b010011;
        5'd19: c = 6'b110010;
        5'd20: c = 6'b001011;
        5'd21: c = 6'b101010;
        5'd22: c = 6'b011010;
        5'd23: c = 6'b111010;
        5'd24: c = 6'b110011;
        5'd25: c = 6'b100110;
        5'd26: c = 6'b010110;
        5'd27: c = 6'b110110;
        5'd28: c = 6'b001110;
        5'd29: c = 6'b101110;
        5'd30: c = 6'b011110;
        default: c = 6'b101011;
      endcase
    end
    return c;
  endfunction

  // the subblock swaps to its complement when the line is positive
  function automatic logic six_swaps(input logic [LOW_W-1:0] x,
                                     input logic k28,
                                     input logic [SIX_W-1:0] neg);
    return ($countones(neg) != 3) || ((x == 5'd7) && !k28);
  endfunction

  // alternate x.7 form, chosen to keep run lengths at five or less
  function automatic logic alt7_pick(input logic [LOW_W-1:0] x,
                                     input logic [HIGH_W-1:0] y,
                                     input logic rd_mid,
                                     input logic k);
    logic hit_neg;
    logic hit_pos;
    hit_neg = (x == 5'd17) || (x == 5'd18) || (x == 5'd20);
    hit_pos = (x == 5'd11) || (x == 5'd13) || (x == 5'd14);
    return (y == 3'd7) && (k || (!rd_mid && hit_neg) || (rd_mid && hit_pos));
  endfunction

  // 4-bit subblock (fghj) for the negative-disparity column
  function automatic logic [FOUR_W-1:0] four_neg(input logic [HIGH_W-1:0] y,
                                                 input logic k,
                                                 input logic alt);
    logic [FOUR_W-1:0] c;
    unique case (y)
      3'd0: c = 4'b1011;
      3'd1: c = k ? 4'b0110 : 4'b1001;
      3'd2: c = k ? 4'b1010 : 4'b0101;
      3'd3: c = 4'b1100;
      3'd4: c = 4'b1101;
      3'd5: c = k ? 4'b0101 : 4'b1010;
      3'd6: c = k ? 4'b1001 : 4'b0110;
      default: c = alt ? 4'b0111 : 4'b1110;
    endcase
    return c;
  endfunction

  function automatic logic four_swaps(input logic [HIGH_W-1:0] y,
                                      input logic k,
                                      input logic [FOUR_W-1:0] neg);
    logic kswap;
    kswap = k && ((y == 3'd1) || (y == 3'd2) || (y == 3'd5) || (y == 3'd6));
    return ($countones(neg) != 2) || (y == 3'd3) || kswap;
  endfunction

  // the twelve legal control characters
  function automatic logic k_is_legal(input logic [LOW_W-1:0] x,
                                      input logic [HIGH_W-1:0] y);
    logic k7;
    k7 = (x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30);
    return (x == 5'd28) || ((y == 3'd7) && k7);
  endfunction

endpackage

// File: rtl/txenc_kcheck.sv
module txenc_kcheck
  import txenc_pkg::*;
(
  input  logic [DATA_W-1:0] byte_in,
  input  logic              ctrl_in,
  output logic              k_use,
  output logic              k_bad
);
  logic legal;

  assign legal = k_is_legal(byte_in[LOW_W-1:0], byte_in[DATA_W-1:LOW_W]);
  assign k_use = ctrl_in && legal;
  assign k_bad = ctrl_in && !legal;
endmodule

// File: rtl/txenc_sub6.sv
module txenc_sub6
  import txenc_pkg::*;
(
  input  logic [LOW_W-1:0] x,
  input  logic             k,
  input  logic             rd_in,
  output logic [SIX_W-1:0] code6,
  output logic             rd_out
);
  logic             k28;
  logic [SIX_W-1:0] base;
  logic             swaps;
  logic             flips;

  assign k28   = k && (x == 5'd28);
  assign base  = six_neg(x, k28);
  assign swaps = six_swaps(x, k28, base);
  assign flips = ($countones(base) != 3);

  always_comb begin
    code6  = (rd_in && swaps) ? ~base : base;
    rd_out = rd_in ^ flips;
  end
endmodule

// File: rtl/txenc_sub4.sv
module txenc_sub4
  import txenc_pkg::*;
(
  input  logic [HIGH_W-1:0] y,
  input  logic [LOW_W-1:0]  x,
  input  logic              k,
  input  logic              rd_in,
  output logic [FOUR_W-1:0] code4,
  output logic              rd_out,
  output logic              alt_used
);
  logic [FOUR_W-1:0] base;
  logic              swaps;
  logic              flips;

  assign alt_used = alt7_pick(x, y, rd_in, k);
  assign base     = four_neg(y, k, alt_used);
  assign swaps    = four_swaps(y, k, base);
  assign flips    = ($countones(base) != 2);

  always_comb begin
    code4  = (rd_in && swaps) ? ~base : base;
    rd_out = rd_in ^ flips;
  end
endmodule

// File: rtl/tx_char_encoder.sv
module tx_char_encoder
  import txenc_pkg::*;
#(
  parameter logic RESET_RD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_ctrl,
  input  logic              in_force,
  input  logic              in_dispval,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic              out_rd,
  output logic              out_kerr
);
  // named internal events, observed by the bound checker
  logic              rd_start;
  logic              rd_mid;
  logic              rd_end;
  logic              k_use;
  logic              k_bad;
  logic              alt_used;
  logic [SIX_W-1:0]  code6;
  logic [FOUR_W-1:0] code4;

  assign rd_start = in_force ? in_dispval : out_rd;

  txenc_kcheck u_kchk (
    .byte_in (in_data),
    .ctrl_in (in_ctrl),
    .k_use   (k_use),
    .k_bad   (k_bad)
  );

  txenc_sub6 u_six (
    .x      (in_data[LOW_W-1:0]),
    .k      (k_use),
    .rd_in  (rd_start),
    .code6  (code6),
    .rd_out (rd_mid)
  );

  txenc_sub4 u_four (
    .y        (in_data[DATA_W-1:LOW_W]),
    .x        (in_data[LOW_W-1:0]),
    .k        (k_use),
    .rd_in    (rd_mid),
    .code4    (code4),
    .rd_out   (rd_end),
    .alt_used (alt_used)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_rd    <= RESET_RD;
      out_kerr  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_kerr  <= in_valid && k_bad;
      if (in_valid) begin
        out_code <= {code6, code4};
        out_rd   <= rd_end;
      end
    end
  end
endmodule

// File: rtl/tx_char_encoder_chk.sv
module tx_char_encoder_chk
  import txenc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_force,
  input logic              in_dispval,
  input logic              out_valid,
  input logic [CODE_W-1:0] out_code,
  input logic              out_rd,
  input logic              out_kerr,
  input logic              rd_start
);
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == ($past(in_valid) && $past(rst_n)));

  p_weight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (($countones(out_code) >= 4) && ($countones(out_code) <= 6)));

  p_heavy_from_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($countones(out_code) == 6)) |-> !$past(rd_start));

  p_light_from_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($countones(out_code) == 4)) |-> $past(rd_start));

  p_rd_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rd == ($past(rd_start) ^ ($countones(out_code) != 5))));

  p_force_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_force && !in_dispval) |=> ($countones(out_code) != 4));

  p_unforced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_force) |=> (out_rd == ($past(out_rd) ^ ($countones(out_code) != 5))));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_kerr && $stable(out_rd)));

  p_kerr_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_kerr |-> out_valid);
endmodule

bind tx_char_encoder tx_char_encoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_force   (in_force),
  .in_dispval (in_dispval),
  .out_valid  (out_valid),
  .out_code   (out_code),
  .out_rd     (out_rd),
  .out_kerr   (out_kerr),
  .rd_start   (rd_start)
);

// File: tb/sim_tx_char_encoder.sv
module sim_tx_char_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ctrl = 1'b0;
  logic       in_force = 1'b0;
  logic       in_dispval = 1'b0;
  logic       out_valid;
  logic [9:0] out_code;
  logic       out_rd;
  logic       out_kerr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_char_encoder u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ctrl    (in_ctrl),
    .in_force   (in_force),
    .in_dispval (in_dispval),
    .out_valid  (out_valid),
    .out_code   (out_code),
    .out_rd     (out_rd),
    .out_kerr   (out_kerr)
  );

  typedef struct packed {
    logic       vld;
    logic [9:0] code;
    logic       rd;
    logic       kerr;
    int         stamp;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  logic  mrd = 1'b0;
  logic  finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference tables written as both disparity columns {negative, positive}
  function automatic logic [11:0] ref6(input logic [4:0] x, input logic k28);
    if (k28) return {6'b001111, 6'b110000};
    case (x)
      5'd0:  return {6'b100111, 6'b011000};
      5'd1:  return {6'b011101, 6'b100010};
      5'd2:  return {6'b101101, 6'b010010};
      5'd3:  return {6'b110001, 6'b110001};
      5'd4:  return {6'b110101, 6'b001010};
      5'd5:  return {6'b101001, 6'b101001};
      5'd6:  return {6'b011001, 6'b011001};
      5'd7:  return {6'b111000, 6'b000111};
      5'd8:  return {6'b111001, 6'b000110};
      5'd9:  return {6'b100101, 6'b100101};
      5'd10: return {6'b010101, 6'b010101};
      5'd11: return {6'b110100, 6'b110100};
      5'd12: return {6'b001101, 6'b001101};
      5'd13: return {6'b101100, 6'b101100};
      5'd14: return {6'b011100, 6'b011100};
      5'd15: return {6'b010111, 6'b101000};
      5'd16: return {6'b011011, 6'b100100};
      5'd17: return {6'b100011, 6'b100011};
      5'd18: return {6'b010011, 6'b010011};
      5'd19: return {6'b110010, 6'b110010};
      5'd20: return {6'b001011, 6'b001011};
      5'd21: return {6'b101010, 6'b101010};
      5'd22: return {6'b011010, 6'b011010};
      5'd23: return {6'b111010, 6'b000101};
      5'd24: return {6'b110011, 6'b001100};
      5'd25: return {6'b100110, 6'b100110};
      5'd26: return {6'b010110, 6'b010110};
      5'd27: return {6'b110110, 6'b001001};
      5'd28: return {6'b001110, 6'b001110};
      5'd29: return {6'b101110, 6'b010001};
      5'd30: return {6'b011110, 6'b100001};
      default: return {6'b101011, 6'b010100};
    endcase
  endfunction

  function automatic logic [7:0] ref4(input logic [2:0] y, input logic k, input logic alt);
    if (k) begin
      case (y)
        3'd1: return {4'b0110, 4'b1001};
        3'd2: return {4'b1010, 4'b0101};
        3'd5: return {4'b0101, 4'b1010};
        3'd6: return {4'b1001, 4'b0110};
        3'd7: return {4'b0111, 4'b1000};
        default: ;
      endcase
    end
    case (y)
      3'd0: return {4'b1011, 4'b0100};
      3'd1: return {4'b1001, 4'b1001};
      3'd2: return {4'b0101, 4'b0101};
      3'd3: return {4'b1100, 4'b0011};
      3'd4: return {4'b1101, 4'b0010};
      3'd5: return {4'b1010, 4'b1010};
      3'd6: return {4'b0110, 4'b0110};
      default: return alt ? {4'b0111, 4'b1000} : {4'b1110, 4'b0001};
    endcase
  endfunction

  // returns {code, end disparity, kerr}
  function automatic logic [11:0] ref_enc(input logic [7:0] d, input logic k, input logic rd);
    logic [4:0]  x;
    logic [2:0]  y;
    logic        legal;
    logic        ke;
    logic [11:0] p6;
    logic [7:0]  p4;
    logic [5:0]  s6;
    logic [3:0]  s4;
    logic        rm;
    logic        re;
    logic        alt;
    x = d[4:0];
    y = d[7:5];
    legal = (x == 5'd28) || (y == 3'd7 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
    ke = k && legal;
    p6 = ref6(x, ke && x == 5'd28);
    s6 = rd ? p6[5:0] : p6[11:6];
    rm = ($countones(s6) == 3) ? rd : ~rd;
    alt = (y == 3'd7) && (ke || (!rm && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                                (rm && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    p4 = ref4(y, ke, alt);
    s4 = rm ? p4[3:0] : p4[7:4];
    re = ($countones(s4) == 2) ? rm : ~rm;
    return {s6, s4, re, k && !legal};
  endfunction

  task automatic push(input logic v, input logic [9:0] c, input logic r, input logic e, input string tag);
    exp_t it;
    it.vld = v; it.code = c; it.rd = r; it.kerr = e; it.stamp = cyc;
    q_exp.push_back(it);
    q_tag.push_back(tag);
  endtask

  task automatic send(input logic [7:0] d, input logic k, input logic f, input logic dv, input string tag);
    logic [11:0] r;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_ctrl = k; in_force = f; in_dispval = dv;
    r = ref_enc(d, k, f ? dv : mrd);
    mrd = r[1];
    push(1'b1, r[11:2], r[1], r[0], tag);
  endtask

  // expected code given as a literal, disparity from the model
  task automatic send_lit(input logic [7:0] d, input logic k, input logic dv, input logic [9:0] lit, input string tag);
    logic [11:0] r;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_ctrl = k; in_force = 1'b1; in_dispval = dv;
    r = ref_enc(d, k, dv);
    mrd = r[1];
    push(1'b1, lit, r[1], 1'b0, tag);
  endtask

  task automatic idle(input logic f, input logic dv, input string tag);
    @(negedge clk);
    in_valid = 1'b0; in_data = 8'hBC; in_ctrl = 1'b1; in_force = f; in_dispval = dv;
    push(1'b0, 10'h000, mrd, 1'b0, tag);
  endtask

  // monitor: compares the item driven one clock earlier
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      while (q_exp.size() > 0 && q_exp[0].stamp < cyc) begin
        exp_t  e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        n_cmp++;
        if (e.vld) begin
          if (!(out_valid && out_code == e.code && out_rd == e.rd && out_kerr == e.kerr)) begin
            n_bad++;
            $display("FAIL %s: got vld=%b code=%b rd=%b kerr=%b, expected vld=1 code=%b rd=%b kerr=%b",
                     t, out_valid, out_code, out_rd, out_kerr, e.code, e.rd, e.kerr);
          end
        end else begin
          if (!(!out_valid && !out_kerr && out_rd == e.rd)) begin
            n_bad++;
            $display("FAIL %s: got vld=%b kerr=%b rd=%b, expected vld=0 kerr=0 rd=%b",
                     t, out_valid, out_kerr, out_rd, e.rd);
          end
        end
      end
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || out_rd !== 1'b0 || out_kerr !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset: got vld=%b rd=%b kerr=%b, expected 0 0 0", out_valid, out_rd, out_kerr);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || out_rd !== 1'b0 || out_kerr !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 after reset: got vld=%b rd=%b kerr=%b, expected 0 0 0", out_valid, out_rd, out_kerr);
    end

    // literal known characters (R3, R6, R7)
    send_lit(8'h00, 1'b0, 1'b0, 10'b1001110100, "R3 D.0.0 neg");
    send_lit(8'hEB, 1'b0, 1'b1, 10'b1101001000, "R3 R6 D.11.7 pos");
    send_lit(8'hF1, 1'b0, 1'b0, 10'b1000110111, "R6 D.17.7 neg");
    send_lit(8'hBC, 1'b1, 1'b0, 10'b0011111010, "R7 K28.5 neg");
    send_lit(8'hBC, 1'b1, 1'b1, 10'b1100000101, "R7 K28.5 pos");
    idle(1'b0, 1'b0, "R11 gap");

    // R2 / R4: unforced sweep of every data byte, tracked disparity
    for (int i = 0; i < 256; i++) send(i[7:0], 1'b0, 1'b0, 1'b0, "R3 R4 sweep");
    // R6 / R9: every byte from each forced start
    for (int i = 0; i < 256; i++) send(i[7:0], 1'b0, 1'b1, 1'b0, "R6 R9 forced neg");
    for (int i = 0; i < 256; i++) send(i[7:0], 1'b0, 1'b1, 1'b1, "R6 R9 forced pos");

    // R7: the twelve control characters, tracked and forced
    for (int i = 0; i < 8; i++) begin
      send({i[2:0], 5'd28}, 1'b1, 1'b0, 1'b0, "R7 K28 tracked");
      send({i[2:0], 5'd28}, 1'b1, 1'b0, 1'b0, "R7 K28 tracked again");
      send({i[2:0], 5'd28}, 1'b1, 1'b1, 1'b1, "R7 K28 forced pos");
    end
    for (int j = 0; j < 4; j++) begin
      logic [4:0] kx;
      kx = (j == 0) ? 5'd23 : (j == 1) ? 5'd27 : (j == 2) ? 5'd29 : 5'd30;
      send({3'd7, kx}, 1'b1, 1'b1, 1'b0, "R7 Kx.7 forced neg");
      send({3'd7, kx}, 1'b1, 1'b1, 1'b1, "R7 Kx.7 forced pos");
    end

    // R8: illegal control bytes, also combined with override (R9)
    send(8'h00, 1'b1, 1'b0, 1'b0, "R8 K0.0 illegal");
    send(8'hFF, 1'b1, 1'b0, 1'b0, "R8 K31.7 illegal");
    send(8'hF1, 1'b1, 1'b1, 1'b0, "R8 R9 illegal K17.7 forced neg");
    send(8'hEB, 1'b1, 1'b1, 1'b1, "R8 R9 illegal K11.7 forced pos");
    send(8'h4A, 1'b1, 1'b1, 1'b1, "R8 R9 illegal K10.2 forced pos");
    send(8'h4A, 1'b0, 1'b0, 1'b0, "R8 clears on data");

    // R10: in_dispval toggled with force low
    for (int i = 0; i < 16; i++) send(8'h07 + i[7:0] * 8'd13, 1'b0, 1'b0, i[0], "R10 dispval ignored");

    // R11: idle cycles with force and value wiggling
    idle(1'b1, 1'b1, "R11 idle force pos");
    idle(1'b1, 1'b0, "R11 idle force neg");
    send(8'h0F, 1'b0, 1'b0, 1'b0, "R9 R11 continue after idle");
    idle(1'b1, ~mrd, "R11 idle force opposite");
    send(8'h03, 1'b0, 1'b0, 1'b1, "R4 R11 tracked after idle");
    idle(1'b0, 1'b0, "R11 final idle");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule